// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a dot-clocked parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, the current pixel coordinate and a frame-completion interrupt. Software programs the raster through a small write-only register port. Horizontal quantities are given in units of eight dots. Vertical quantities are given in lines. Each sync can be made active low.

Timing advances only on cycles where the dot-clock enable is high, so the block runs from the system clock and follows a slower pixel rate. There are two refresh styles. In continuous refresh, frames follow one another for as long as the run bit is set. In one-shot refresh, a frame is drawn only after software writes the trigger register. After that frame the syncs go back to their inactive levels until the next trigger. This one-shot style suits panels that keep their own frame memory.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, de, irq, pix_x and pix_y are 0. hsync and vsync are 0, because both polarity bits reset to 0 (active high).
- R2: When running, pix_x counts dots from 0. It equals unit*8 + dot, where the dot index 0..7 advances on each enabled cycle. A line is H_TOTAL units long, and pix_y wraps after V_TOTAL lines. Register 1 holds H_TOTAL in bits 15:0 and H_ACTIVE in bits 31:16. Register 3 holds V_TOTAL in bits 15:0 and V_ACTIVE in bits 31:16.
- R3: de is 1 exactly when a frame is in progress, pix_x < H_ACTIVE*8 and pix_y < V_ACTIVE.
- R4: The raw horizontal sync is active while H_SYNC_START*8 <= pix_x < (H_SYNC_START+H_SYNC_WIDTH)*8. Register 2 holds the start in bits 15:0 and the width in bits 31:16. The raw vertical sync is active while V_SYNC_START <= pix_y < V_SYNC_START+V_SYNC_WIDTH. Register 4 holds the start in bits 15:0 and the width in bits 31:16. Both raw syncs are inactive when no frame is in progress.
- R5: In mode register 5, bit 27 set inverts hsync (active low) and bit 28 set inverts vsync (active low).
- R6: While dot_en is 0, pix_x, pix_y, de and the syncs hold their values.
- R7: Bit 0 of control register 0 is the run bit. Setting it starts frames from coordinate (0,0) one cycle after the write takes effect. Clearing it returns the block to idle, with coordinates 0 and de low.
- R8: Bit 0 of mode register 5 selects one-shot refresh (1) or continuous refresh (0). In one-shot refresh, writing register 6 with bit 0 set starts a single frame. After the last dot of that frame the block stays idle.
- R9: In one-shot refresh, a trigger written during a frame is held and starts the next frame right after the current one ends. A trigger written in continuous refresh or while stopped is discarded.
- R10: The last dot of every frame sets a status flag. irq equals the flag AND bit 10 of interrupt register 7. Writing register 7 with bit 1 = 0 clears the flag. Writing it with bit 1 = 1 leaves the flag unchanged. A frame end in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot-clock enable, one dot per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable |
| pix_x | output | 19 | Dot index within the line |
| pix_y | output | 16 | Line index within the frame |
| irq | output | 1 | Frame-end interrupt |

## Verification
Random raster geometries are run with a random dot-enable pattern. This separates the dot and unit stepping from the line wrap, and shows whether sync windows and de are decoded against the right count. Random polarity choices separate the raw sync windows from their inverted forms. Directed sequences cover the remaining behaviour. A frozen dot enable shows that nothing advances without a dot. Stopping shows the return to idle. A one-shot frame, a mid-frame trigger and a trigger written during continuous refresh separate a single-frame run, a held trigger and a discarded one. Interrupt writes with the keep bit set or clear show which write clears the flag.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    localparam int FIELD_W = 16;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
    localparam logic [ADDR_W-1:0] A_HSYN = 3'd2;
    localparam logic [ADDR_W-1:0] A_VTIM = 3'd3;
    localparam logic [ADDR_W-1:0] A_VSYN = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd5;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd6;
    localparam logic [ADDR_W-1:0] A_INTR = 3'd7;

    localparam int HPOL_BIT = 27;
    localparam int VPOL_BIT = 28;
    localparam int IEN_BIT  = 10;
    localparam int KEEP_BIT = 1;

    typedef struct packed {
        logic               run;
        logic               oneshot;
        logic               hpol_low;
        logic               vpol_low;
        logic [FIELD_W-1:0] h_total;
        logic [FIELD_W-1:0] h_active;
        logic [FIELD_W-1:0] h_sync_start;
        logic [FIELD_W-1:0] h_sync_width;
        logic [FIELD_W-1:0] v_total;
        logic [FIELD_W-1:0] v_active;
        logic [FIELD_W-1:0] v_sync_start;
        logic [FIELD_W-1:0] v_sync_width;
    } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              frame_end,
    output tg_cfg_t           cfg,
    output logic              trig,
    output logic              irq
);
    typedef struct packed {
        tg_cfg_t cfg;
        logic    ien;
        logic    stat;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: d.cfg.run = reg_wdata[0];
                A_HTIM: begin
                    d.cfg.h_total  = reg_wdata[FIELD_W-1:0];
                    d.cfg.h_active = reg_wdata[DATA_W-1:FIELD_W];
                end
                A_HSYN: begin
                    d.cfg.h_sync_start = reg_wdata[FIELD_W-1:0];
                    d.cfg.h_sync_width = reg_wdata[DATA_W-1:FIELD_W];
                end
                A_VTIM: begin
                    d.cfg.v_total  = reg_wdata[FIELD_W-1:0];
                    d.cfg.v_active = reg_wdata[DATA_W-1:FIELD_W];
                end
                A_VSYN: begin
                    d.cfg.v_sync_start = reg_wdata[FIELD_W-1:0];
                    d.cfg.v_sync_width = reg_wdata[DATA_W-1:FIELD_W];
                end
                A_MODE: begin
                    d.cfg.oneshot  = reg_wdata[0];
                    d.cfg.hpol_low = reg_wdata[HPOL_BIT];
                    d.cfg.vpol_low = reg_wdata[VPOL_BIT];
                end
                A_INTR: begin
                    d.ien = reg_wdata[IEN_BIT];
                    if (!reg_wdata[KEEP_BIT]) d.stat = 1'b0;
                end
                default: ;
            endcase
        end
        if (frame_end) d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg  = q.cfg;
    assign trig = reg_wr && (reg_addr == A_TRIG) && reg_wdata[0];
    assign irq  = q.stat && q.ien;

    // R10
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat) |-> $past(frame_end));
endmodule

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq
    import lcd_tg_pkg::*;
#(
    parameter int SUB_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dot_en,
    input  tg_cfg_t             cfg,
    input  logic                trig,
    output logic                active,
    output logic [SUB_BITS-1:0] dot,
    output logic [FIELD_W-1:0]  unit,
    output logic [FIELD_W-1:0]  line,
    output logic                frame_end
);
    localparam logic [SUB_BITS-1:0] DOT_LAST = '1;
    localparam logic [FIELD_W:0]    ONE_W    = 1;

    typedef struct packed {
        logic                act;
        logic                pend;
        logic [SUB_BITS-1:0] dot;
        logic [FIELD_W-1:0]  unit;
        logic [FIELD_W-1:0]  line;
    } seq_t;

    seq_t q, d;
    logic start;
    logic fe;

    always_comb begin
        d     = q;
        fe    = 1'b0;
        start = 1'b0;
        if (!cfg.run) begin
            d = '0;
        end else begin
            start = !q.act && (cfg.oneshot ? q.pend : 1'b1);
            if (start) begin
                d.act  = 1'b1;
                d.dot  = '0;
                d.unit = '0;
                d.line = '0;
                if (cfg.oneshot) d.pend = 1'b0;
            end else if (q.act && dot_en) begin
                if (q.dot == DOT_LAST) begin
                    d.dot = '0;
                    if (({1'b0, q.unit} + ONE_W) >= {1'b0, cfg.h_total}) begin
                        d.unit = '0;
                        if (({1'b0, q.line} + ONE_W) >= {1'b0, cfg.v_total}) begin
                            d.line = '0;
                            fe     = 1'b1;
                            if (cfg.oneshot) d.act = 1'b0;
                        end else begin
                            d.line = q.line + 1'b1;
                        end
                    end else begin
                        d.unit = q.unit + 1'b1;
                    end
                end else begin
                    d.dot = q.dot + 1'b1;
                end
            end
            if (trig && cfg.oneshot) d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active    = q.act;
    assign dot       = q.dot;
    assign unit      = q.unit;
    assign line      = q.line;
    assign frame_end = fe;

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && !dot_en && cfg.run) |=> ($stable(q.dot) && $stable(q.unit) && $stable(q.line)));
    // R8
    oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cfg.oneshot) |=> !q.act);
    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && $stable(cfg.v_total) && $past(q.act)) |-> ({1'b0, q.line} < {1'b0, cfg.v_total} || cfg.v_total == '0));
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out
    import lcd_tg_pkg::*;
#(
    parameter int SUB_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tg_cfg_t                     cfg,
    input  logic                        active,
    input  logic [SUB_BITS-1:0]         dot,
    input  logic [FIELD_W-1:0]          unit,
    input  logic [FIELD_W-1:0]          line,
    output logic                        hsync,
    output logic                        vsync,
    output logic                        de,
    output logic [FIELD_W+SUB_BITS-1:0] pix_x,
    output logic [FIELD_W-1:0]          pix_y
);
    logic [FIELD_W:0] h_end, v_end;
    logic             hs_raw, vs_raw;

    always_comb begin
        h_end  = {1'b0, cfg.h_sync_start} + {1'b0, cfg.h_sync_width};
        v_end  = {1'b0, cfg.v_sync_start} + {1'b0, cfg.v_sync_width};
        hs_raw = active && (unit >= cfg.h_sync_start) && ({1'b0, unit} < h_end);
        vs_raw = active && (line >= cfg.v_sync_start) && ({1'b0, line} < v_end);
        de     = active && (unit < cfg.h_active) && (line < cfg.v_active);
        hsync  = hs_raw ^ cfg.hpol_low;
        vsync  = vs_raw ^ cfg.vpol_low;
        pix_x  = active ? {unit, dot} : '0;
        pix_y  = active ? line : '0;
    end

    // R3
    de_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pix_x < {cfg.h_active, {SUB_BITS{1'b0}}}));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int SUB_BITS = 3,
    localparam int X_W     = FIELD_W + SUB_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [X_W-1:0]    pix_x,
    output logic [FIELD_W-1:0] pix_y,
    output logic              irq
);
    tg_cfg_t             cfg;
    logic                trig;
    logic                frame_end;
    logic                active;
    logic [SUB_BITS-1:0] dot;
    logic [FIELD_W-1:0]  unit;
    logic [FIELD_W-1:0]  line;

    lcd_tg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_end(frame_end), .cfg(cfg),
        .trig(trig), .irq(irq)
    );

    lcd_tg_seq #(.SUB_BITS(SUB_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .cfg(cfg), .trig(trig),
        .active(active), .dot(dot), .unit(unit), .line(line),
        .frame_end(frame_end)
    );

    lcd_tg_out #(.SUB_BITS(SUB_BITS)) u_out (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .active(active), .dot(dot),
        .unit(unit), .line(line), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.run |=> (!de && pix_x == '0));
endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        hsync, vsync, de, irq;
    logic [18:0] pix_x;
    logic [15:0] pix_y;

    int n_tests = 0;
    int n_fail  = 0;

    // bench reference state
    bit m_run, m_os, m_hpl, m_vpl, m_act, m_pend, m_ie, m_st;
    int ht, ha, hs, hw, vt, va, vs, vw;
    int m_dot, m_unit, m_line;

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hsync(hsync),
        .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit exp_de();
        return m_act && (m_unit < ha) && (m_line < va);
    endfunction
    function automatic bit exp_hs();
        return (m_act && m_unit >= hs && m_unit < hs + hw) ^ m_hpl;
    endfunction
    function automatic bit exp_vs();
        return (m_act && m_line >= vs && m_line < vs + vw) ^ m_vpl;
    endfunction

    task automatic model_step(input bit w, input logic [2:0] a, input logic [31:0] dt, input bit e);
        bit fe = 1'b0;
        if (!m_run) begin
            m_act = 0; m_pend = 0; m_dot = 0; m_unit = 0; m_line = 0;
        end else begin
            bit npend = m_pend;
            if (!m_act && (m_os ? m_pend : 1'b1)) begin
                m_act = 1; m_dot = 0; m_unit = 0; m_line = 0;
                if (m_os) npend = 0;
            end else if (m_act && e) begin
                if (m_dot == 7) begin
                    m_dot = 0;
                    if (m_unit + 1 >= ht) begin
                        m_unit = 0;
                        if (m_line + 1 >= vt) begin
                            m_line = 0; fe = 1;
                            if (m_os) m_act = 0;
                        end else m_line++;
                    end else m_unit++;
                end else m_dot++;
            end
            if (w && a == 3'd6 && dt[0] && m_os) npend = 1;
            m_pend = npend;
        end
        if (w) begin
            case (a)
                3'd0: m_run = dt[0];
                3'd1: begin ht = dt[15:0]; ha = dt[31:16]; end
                3'd2: begin hs = dt[15:0]; hw = dt[31:16]; end
                3'd3: begin vt = dt[15:0]; va = dt[31:16]; end
                3'd4: begin vs = dt[15:0]; vw = dt[31:16]; end
                3'd5: begin m_os = dt[0]; m_hpl = dt[27]; m_vpl = dt[28]; end
                3'd7: begin m_ie = dt[10]; if (!dt[1]) m_st = 0; end
                default: ;
            endcase
        end
        if (fe) m_st = 1;
    endtask

    task automatic compare_all();
        check("R2 pix_x", 32'(pix_x), 32'(m_act ? m_unit * 8 + m_dot : 0));
        check("R2 pix_y", 32'(pix_y), 32'(m_act ? m_line : 0));
        check("R3 de", 32'(de), 32'(exp_de()));
        check(m_hpl ? "R5 hsync" : "R4 hsync", 32'(hsync), 32'(exp_hs()));
        check(m_vpl ? "R5 vsync" : "R4 vsync", 32'(vsync), 32'(exp_vs()));
        check("R10 irq", 32'(irq), 32'(m_st && m_ie));
    endtask

    task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] dt, input bit e);
        reg_wr = w; reg_addr = a; reg_wdata = dt; dot_en = e;
        @(posedge clk);
        model_step(w, a, dt, e);
        @(negedge clk);
        reg_wr = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] dt);
        cyc(1'b1, a, dt, 1'b1);
    endtask

    task automatic run_dots(input int n, input int en_pct);
        for (int i = 0; i < n; i++) begin
            bit e = ($urandom % 100) < en_pct;
            if (($urandom % 60) == 0)
                cyc(1'b1, 3'd7, {21'd0, m_ie, 8'd0, ($urandom % 2 == 1), 1'b0}, e);
            else
                cyc(1'b0, 3'd0, 32'd0, e);
        end
    endtask

    task automatic program_random(input bit os);
        int t, a2, s, w2, vt2, va2, vs2, vw2;
        t = 4 + $urandom % 4;  a2 = 1 + $urandom % (t - 1);
        s = $urandom % t;      w2 = 1 + $urandom % 2;
        vt2 = 3 + $urandom % 4; va2 = 1 + $urandom % vt2;
        vs2 = $urandom % vt2;  vw2 = 1 + $urandom % 2;
        wr(3'd1, {16'(a2), 16'(t)});
        wr(3'd2, {16'(w2), 16'(s)});
        wr(3'd3, {16'(va2), 16'(vt2)});
        wr(3'd4, {16'(vw2), 16'(vs2)});
        wr(3'd5, {3'd0, 1'($urandom % 2), 1'($urandom % 2), 26'd0, os});
        wr(3'd7, 32'h0000_0400);
    endtask

    initial begin
        #(8 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [18:0] px_hold;
        logic [15:0] py_hold;
        int flen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 de", 32'(de), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 pix_x", 32'(pix_x), 0);
        check("R1 pix_y", 32'(pix_y), 0);
        check("R1 hsync", 32'(hsync), 0);
        check("R1 vsync", 32'(vsync), 0);

        // continuous refresh with random geometry
        for (int r = 0; r < 8; r++) begin
            wr(3'd0, 32'd0);
            program_random(1'b0);
            wr(3'd0, 32'd1);
            run_dots(ht * 8 * vt * 5 / 2, 75);
        end

        // R6 frozen dot enable
        run_dots(13, 100);
        px_hold = pix_x; py_hold = pix_y;
        for (int i = 0; i < 4; i++) cyc(1'b0, 3'd0, 32'd0, 1'b0);
        check("R6 pix_x hold", 32'(pix_x), 32'(px_hold));
        check("R6 pix_y hold", 32'(pix_y), 32'(py_hold));

        // R7 stop returns to idle
        wr(3'd0, 32'd0);
        cyc(1'b0, 3'd0, 32'd0, 1'b1);
        check("R7 stopped pix_x", 32'(pix_x), 0);
        check("R7 stopped de", 32'(de), 0);

        // R8 one-shot: idle until trigger, single frame
        program_random(1'b1);
        wr(3'd0, 32'd1);
        run_dots(20, 100);
        check("R8 idle before trigger", 32'(pix_x), 0);
        check("R8 idle de", 32'(de), 0);
        flen = ht * 8 * vt;
        wr(3'd6, 32'd1);
        run_dots(1 + flen, 100);
        check("R8 idle after frame", 32'(pix_x), 0);
        check("R10 irq after oneshot frame", 32'(irq), 1);
        wr(3'd7, 32'h0000_0402);
        check("R10 keep bit holds flag", 32'(irq), 1);
        wr(3'd7, 32'h0000_0400);
        check("R10 clear write", 32'(irq), 0);
        run_dots(10, 100);
        check("R8 stays idle", 32'(de), 0);

        // R9 trigger during frame is held
        wr(3'd6, 32'd1);
        run_dots(5, 100);
        wr(3'd6, 32'd1);
        run_dots(flen - 6, 100);
        run_dots(3, 100);
        check("R9 held trigger restarts", 32'(pix_x != 0), 1);
        run_dots(flen + 5, 100);
        check("R9 idle after second frame", 32'(pix_x), 0);

        // R9 trigger in continuous refresh discarded
        wr(3'd5, 32'd0);
        run_dots(10, 100);
        wr(3'd6, 32'd1);
        wr(3'd5, 32'd1);
        run_dots(flen + 30, 100);
        check("R9 continuous trigger dropped", 32'(pix_x), 0);
        check("R9 continuous trigger dropped de", 32'(de), 0);

        // random one-shot traffic
        for (int r = 0; r < 4; r++) begin
            wr(3'd0, 32'd0);
            program_random(1'b1);
            wr(3'd0, 32'd1);
            for (int k = 0; k < 3; k++) begin
                wr(3'd6, 32'd1);
                run_dots(ht * 8 * vt * 3 / 2, 80);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule